// File: doc/BRIEF.md
# CPU Core Power-Up Sequencer

This block brings a single processor core out of power collapse in hardware. A one-cycle start pulse launches a fixed, ordered walk through the core's power-control signals. The walk first clamps and resets everything, then turns on the power-gate head switch with its switch count. After that it releases the memory clamp, enables the memory head switch, releases the logic clamp, and finally releases both resets together. The last step raises a powered-up flag. Microsecond-scale settling waits separate the steps. Their length comes from a clock-cycles-per-microsecond parameter, so the same RTL serves any clock rate.

Each power-control signal appears as its own output. The same state is also offered as a packed 8-bit control view and a packed 32-bit gate view, for use by observation logic. A done level marks the end of the sequence and holds until the next start. A start pulse that arrives while the walk is in progress is ignored.

Top module: `core_pwrup_seq`

## Requirements
- R1: A synchronous active-low reset returns the block to idle. After reset the control view reads 0x33, the gate view reads 0x00000000, and done and busy are both low.
- R2: A start pulse taken in idle or done is applied at clock edge 0. After edge 0 the control view reads 0x33, the gate view reads 0x00000000, done is low and busy is high.
- R3: At edge 1 the gate view becomes 0x10000001. Bit 0 is the gate enable. Bits 31:24 hold the switch count SW_COUNT, which defaults to 16.
- R4: Each settling wait lasts N = WAIT_US*CYC_PER_US cycles. The bench uses N=10.
- R5: At edge N+1 the memory clamp (bit 1) drops, so the control view reads 0x31. At edge N+2 the memory head switch (bit 3) is set while the logic clamp (bit 0) is still high, so the view reads 0x39.
- R6: At edge 2N+2 the logic clamp is released, and the control view reads 0x38.
- R7: At edge 3N+2 the core reset (bit 4) and the power-on reset (bit 5) drop in the same cycle, and the control view reads 0x08. At edge 3N+3 the powered-up flag (bit 7) is set, and the view reads 0x88.
- R8: In the control view, bit 2 (L1 reset-disable) and bit 6 (clock gate) always read 0. Each discrete control output equals its bit in the view.
- R9: Busy is high from edge 0 until edge 3N+3. From edge 3N+3 done is high, and it stays high while no start arrives.
- R10: A start pulse taken while busy has no effect on any output.
- R11: A start pulse taken while done restarts the full sequence from the clamped word, and done drops at edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| clamp_o | output | 1 | Logic clamp, active high |
| mem_clamp_o | output | 1 | Memory clamp, active high |
| core_rst_o | output | 1 | Core reset, active high |
| por_rst_o | output | 1 | Power-on reset, active high |
| mem_hs_o | output | 1 | Memory head switch enable |
| pwrd_up_o | output | 1 | Core powered-up flag |
| gate_en_o | output | 1 | Power-gate head switch enable |
| gate_cnt_o | output | SW_CNT_W | Power-gate switch count |
| ctl_view_o | output | 8 | Packed control word |
| gate_view_o | output | 32 | Packed gate control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held until next start |

## Verification
The hardest situation to reach from the ports is a start pulse that lands inside a settling wait. If that pulse reloaded the timer or the state, the only symptom would be a control-word edge arriving some cycles late.

To catch this, the bench drives the pulse in the middle of the second wait. It then compares every output on every cycle against a cycle-indexed expected trace. Any shift in the trace shows up as a mismatch on a named step. A second stress case applies reset partway through the first wait. A third restarts the sequence from the done state, where the core is fully powered.

// File: rtl/pwrup_pkg.sv
// Shared definitions for the core power-up sequencer.
// Assumes an 8-bit control word with the bit positions defined here.
package pwrup_pkg;

    localparam int CTL_W        = 8;
    localparam int B_CLAMP      = 0;
    localparam int B_MEM_CLAMP  = 1;
    localparam int B_L1_RST_DIS = 2;
    localparam int B_MEM_HS     = 3;
    localparam int B_CORE_RST   = 4;
    localparam int B_POR_RST    = 5;
    localparam int B_CLK_GATE   = 6;
    localparam int B_PWRD_UP    = 7;

    // Fully clamped, held-in-reset word
    localparam logic [CTL_W-1:0] CTL_CLAMPED = 8'h33;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT_A,
        ST_MEMHS,
        ST_WAIT_B,
        ST_WAIT_C,
        ST_PWRUP,
        ST_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_CLAMP_ALL,
        ACT_GATE_ON,
        ACT_MEMCLAMP_OFF,
        ACT_MEMHS_ON,
        ACT_CLAMP_OFF,
        ACT_RESET_OFF,
        ACT_PWRUP
    } seq_act_t;

endpackage

// File: rtl/pwrup_timer.sv
// Down-counter for settling waits.
// A load sets the count to load_val_i. The count then drops by one per cycle
// until it reaches zero. Assumes load_val_i fits in CNT_W bits.
module pwrup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: load, or decrement toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Zero flag
    always_comb zero_o = (cnt_q == '0);

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(load_i)) |-> cnt_q == '0);

endmodule

// File: rtl/pwrup_fsm.sv
// Step sequencer.
// Walks the fixed power-up order and emits one action per step edge.
// Starts the settling timer for each wait. Assumes WAIT_CYC >= 1.
module pwrup_fsm
    import pwrup_pkg::*;
#(
    parameter int WAIT_CYC = 100,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output seq_act_t         act_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYC - 1);

    seq_state_t state_q, state_d;

    // Next state, action and timer load
    always_comb begin
        state_d    = state_q;
        act_o      = ACT_NONE;
        tmr_load_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start_i) begin
                state_d = ST_ARM;
                act_o   = ACT_CLAMP_ALL;
            end
            ST_ARM: begin
                state_d    = ST_WAIT_A;
                act_o      = ACT_GATE_ON;
                tmr_load_o = 1'b1;
            end
            ST_WAIT_A: if (tmr_zero_i) begin
                state_d = ST_MEMHS;
                act_o   = ACT_MEMCLAMP_OFF;
            end
            ST_MEMHS: begin
                state_d    = ST_WAIT_B;
                act_o      = ACT_MEMHS_ON;
                tmr_load_o = 1'b1;
            end
            ST_WAIT_B: if (tmr_zero_i) begin
                state_d    = ST_WAIT_C;
                act_o      = ACT_CLAMP_OFF;
                tmr_load_o = 1'b1;
            end
            ST_WAIT_C: if (tmr_zero_i) begin
                state_d = ST_PWRUP;
                act_o   = ACT_RESET_OFF;
            end
            ST_PWRUP: begin
                state_d = ST_DONE;
                act_o   = ACT_PWRUP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Status decode
    always_comb begin
        tmr_val_o = RELOAD;
        busy_o    = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done_o    = (state_q == ST_DONE);
    end

    a_r4_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) inside {ST_WAIT_A, ST_WAIT_B, ST_WAIT_C} &&
         state_q != $past(state_q)) |-> $past(tmr_zero_i));

    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r10_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != ST_PWRUP) |=> busy_o);

endmodule

// File: rtl/pwrup_ctrl_reg.sv
// Control and gate registers.
// Applies each step action from the sequencer to the control word and the
// gate word. Assumes that only one action arrives per cycle.
module pwrup_ctrl_reg
    import pwrup_pkg::*;
#(
    parameter int SW_CNT_W = 8,
    parameter int SW_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  seq_act_t            act_i,
    output logic [CTL_W-1:0]    ctl_o,
    output logic                gate_en_o,
    output logic [SW_CNT_W-1:0] gate_cnt_o
);
    logic [CTL_W-1:0]    ctl_q;
    logic                gate_en_q;
    logic [SW_CNT_W-1:0] gate_cnt_q;

    // Control word update per action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_CLAMPED;
        end else begin
            unique case (act_i)
                ACT_CLAMP_ALL:    ctl_q <= CTL_CLAMPED;
                ACT_MEMCLAMP_OFF: ctl_q[B_MEM_CLAMP] <= 1'b0;
                ACT_MEMHS_ON:     ctl_q[B_MEM_HS] <= 1'b1;
                ACT_CLAMP_OFF:    ctl_q[B_CLAMP] <= 1'b0;
                ACT_RESET_OFF: begin
                    ctl_q[B_CORE_RST] <= 1'b0;
                    ctl_q[B_POR_RST]  <= 1'b0;
                end
                ACT_PWRUP:        ctl_q[B_PWRD_UP] <= 1'b1;
                default:          ctl_q <= ctl_q;
            endcase
        end
    end

    // Gate word update per action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_en_q  <= 1'b0;
            gate_cnt_q <= '0;
        end else if (act_i == ACT_CLAMP_ALL) begin
            gate_en_q  <= 1'b0;
            gate_cnt_q <= '0;
        end else if (act_i == ACT_GATE_ON) begin
            gate_en_q  <= 1'b1;
            gate_cnt_q <= SW_CNT_W'(SW_COUNT);
        end
    end

    // Output drive
    always_comb begin
        ctl_o      = ctl_q;
        gate_en_o  = gate_en_q;
        gate_cnt_o = gate_cnt_q;
    end

    a_r3_gate_before_memclamp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q[B_MEM_CLAMP]) |-> gate_en_q);

    a_r5_memhs_under_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[B_MEM_HS]) |-> ctl_q[B_CLAMP]);

    a_r7_resets_together: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[B_CORE_RST] == ctl_q[B_POR_RST]);

    a_r7_pwrdup_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[B_PWRD_UP] |-> !ctl_q[B_CORE_RST] && !ctl_q[B_CLAMP]);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[B_L1_RST_DIS] && !ctl_q[B_CLK_GATE]);

endmodule

// File: rtl/core_pwrup_seq.sv
// Core power-up sequencer, top level.
// Connects the step sequencer, the settling timer and the control registers.
// Exposes discrete controls and packed views.
// Assumes WAIT_US*CYC_PER_US >= 1 and SW_COUNT < 2**SW_CNT_W.
module core_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int WAIT_US    = 2,
    parameter int SW_CNT_W   = 8,
    parameter int SW_COUNT   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                clamp_o,
    output logic                mem_clamp_o,
    output logic                core_rst_o,
    output logic                por_rst_o,
    output logic                mem_hs_o,
    output logic                pwrd_up_o,
    output logic                gate_en_o,
    output logic [SW_CNT_W-1:0] gate_cnt_o,
    output logic [7:0]          ctl_view_o,
    output logic [31:0]         gate_view_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int WAIT_CYC = WAIT_US * CYC_PER_US;
    localparam int CNT_W    = $clog2(WAIT_CYC + 1);
    localparam int GAP_W    = 31 - SW_CNT_W;

    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    seq_act_t         act;
    logic [CTL_W-1:0] ctl;

    pwrup_fsm #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .act_o(act),
        .busy_o(busy_o), .done_o(done_o)
    );

    pwrup_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
        .zero_o(tmr_zero)
    );

    pwrup_ctrl_reg #(.SW_CNT_W(SW_CNT_W), .SW_COUNT(SW_COUNT)) creg_i (
        .clk(clk), .rst_n(rst_n), .act_i(act), .ctl_o(ctl),
        .gate_en_o(gate_en_o), .gate_cnt_o(gate_cnt_o)
    );

    // Discrete controls and packed views
    always_comb begin
        clamp_o     = ctl[B_CLAMP];
        mem_clamp_o = ctl[B_MEM_CLAMP];
        core_rst_o  = ctl[B_CORE_RST];
        por_rst_o   = ctl[B_POR_RST];
        mem_hs_o    = ctl[B_MEM_HS];
        pwrd_up_o   = ctl[B_PWRD_UP];
        ctl_view_o  = ctl;
        gate_view_o = {gate_cnt_o, {GAP_W{1'b0}}, gate_en_o};
    end

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

endmodule

// File: tb/core_pwrup_seq_tb_top.sv
module core_pwrup_seq_tb_top;
    localparam int CPU = 5;
    localparam int WUS = 2;
    localparam int N   = CPU * WUS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        clamp_o, mem_clamp_o, core_rst_o, por_rst_o, mem_hs_o, pwrd_up_o;
    logic        gate_en_o, busy_o, done_o;
    logic [7:0]  gate_cnt_o, ctl_view_o;
    logic [31:0] gate_view_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    core_pwrup_seq #(.CYC_PER_US(CPU), .WAIT_US(WUS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .clamp_o(clamp_o), .mem_clamp_o(mem_clamp_o), .core_rst_o(core_rst_o),
        .por_rst_o(por_rst_o), .mem_hs_o(mem_hs_o), .pwrd_up_o(pwrd_up_o),
        .gate_en_o(gate_en_o), .gate_cnt_o(gate_cnt_o), .ctl_view_o(ctl_view_o),
        .gate_view_o(gate_view_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected control view e edges after the start edge (R5 R6 R7)
    function automatic logic [7:0] exp_ctl(input int e);
        if (e <= N)          return 8'h33;
        if (e == N + 1)      return 8'h31;
        if (e <= 2 * N + 1)  return 8'h39;
        if (e <= 3 * N + 1)  return 8'h38;
        if (e == 3 * N + 2)  return 8'h08;
        return 8'h88;
    endfunction

    function automatic string step_tag(input int e);
        if (e == 0)          return "R2";
        if (e == 1)          return "R3";
        if (e <= N + 2)      return "R5";
        if (e <= 2 * N + 2)  return "R6";
        return "R7";
    endfunction

    task automatic check_outputs_vs_view(input string req);
        logic [7:0] d;
        d = 8'h00;
        d[0] = clamp_o; d[1] = mem_clamp_o; d[3] = mem_hs_o;
        d[4] = core_rst_o; d[5] = por_rst_o; d[7] = pwrd_up_o;
        check(d == ctl_view_o && ctl_view_o[2] == 1'b0 && ctl_view_o[6] == 1'b0,
              req, {24'h0, d}, {24'h0, ctl_view_o});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        check(ctl_view_o == 8'h33, "R1", {24'h0, ctl_view_o}, 32'h33);
        check(gate_view_o == 32'h0, "R1", gate_view_o, 32'h0);
        check(!busy_o && !done_o, "R1", {30'h0, busy_o, done_o}, 32'h0);
    endtask

    // Full sequence, optional spurious start at edge index spur_e (R10)
    task automatic t_run(input int spur_e, input string tag);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int e = 0; e <= 3 * N + 6; e++) begin
            logic [31:0] eg;
            bit eb, ed;
            eg = (e == 0) ? 32'h0 : 32'h1000_0001;
            eb = (e < 3 * N + 3);
            ed = !eb;
            check(ctl_view_o == exp_ctl(e), spur_e > 0 ? "R10" : step_tag(e),
                  {24'h0, ctl_view_o}, {24'h0, exp_ctl(e)});
            check(gate_view_o == eg, spur_e > 0 ? "R10" : "R3", gate_view_o, eg);
            check(busy_o == eb && done_o == ed, "R9",
                  {30'h0, busy_o, done_o}, {30'h0, eb, ed});
            check_outputs_vs_view("R8");
            if (e == N + 1)
                check(gate_cnt_o == 8'd16 && gate_en_o, "R4",
                      {24'h0, gate_cnt_o}, 32'd16);
            start_i = (e == spur_e);
            @(negedge clk);
        end
        start_i = 1'b0;
        if (tag != "") $display("scenario %s complete", tag);
    endtask

    task automatic t_mid_reset();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (N / 2 + 2) @(negedge clk);
        check(gate_view_o == 32'h1000_0001 && busy_o, "R3",
              gate_view_o, 32'h1000_0001);
        do_reset();
        t_reset_state();
    endtask

    initial begin
        #(200000 * 20);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset_state();
        repeat (5) @(negedge clk);
        check(ctl_view_o == 8'h33 && !busy_o, "R1", {24'h0, ctl_view_o}, 32'h33);
        t_run(-1, "basic");
        repeat (4) @(negedge clk);
        check(done_o && ctl_view_o == 8'h88, "R9", {31'h0, done_o}, 32'h1);
        t_run(-1, "restart R11");
        t_run(N + 5, "start while busy");
        t_mid_reset();
        t_run(2 * N + 2, "start at clamp release");
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule